// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of a small direct-mapped write-back cache that sits on a shared snooping bus. Each line holds a tag and one of four states: Modified, Exclusive, Shared or Invalid. A processor request (read or write to an address) is served at once when the line state allows it. Otherwise the block raises a bus transaction and completes the request in the cycle its grant arrives. The transaction is a line read, a read with intent to modify, an invalidate, or a copyback of a dirty victim.

At the same time the block watches transactions that other caches put on the bus. A snooped read that finds a valid copy answers with the shared signal and leaves the line Shared. A snooped read-for-ownership or invalidate that finds a copy drops it. In both cases a Modified line first requests a copyback of its contents. The processor holds its request until it is done, and the bus arbiter grants requests from outside.

Address bits below the index width select the line, and the remaining upper bits form the tag. Bus operation codes on both bus ports are 0 = read, 1 = read with intent to modify, 2 = invalidate, 3 = copyback.

Top module: `mesi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid. Whenever no processor request is present, `cpu_done` and `bus_req_valid` are low, and with no snoop `snp_shared` and `snp_flush` are low.
- R2: A read that hits a Modified, Exclusive or Shared line completes in the same cycle with no bus request and no state change.
- R3: A write that hits an Exclusive line completes in the same cycle with no bus request, and the line becomes Modified. A write hit on a Modified line also completes at once and stays Modified.
- R4: A write that hits a Shared line requests operation 2 (invalidate) for its address. It completes in the grant cycle and the line becomes Modified.
- R5: A read miss requests operation 0 for its address. In the grant cycle it completes and fills the line as Shared if `bus_shared_in` is high, else as Exclusive.
- R6: A write miss requests operation 1 for its address. It completes in the grant cycle with the line Modified.
- R7: On a miss whose resident line is Modified with another tag, the block first requests operation 3 with the victim's address (victim tag, same index). That grant does not complete the request and leaves the line Invalid. An Exclusive or Shared victim is replaced with no copyback.
- R8: A snooped read (op 0) that hits a valid line raises `snp_shared` in that cycle and leaves the line Shared. If the line was Modified, `snp_flush` is also raised.
- R9: A snooped op 1 or op 2 that hits a valid line leaves it Invalid. It raises `snp_flush` if the line was Modified and never raises `snp_shared`.
- R10: A snoop that misses (Invalid line or other tag), or a snooped copyback, produces no response and changes no state.
- R11: When a snoop and a processor request address the same index in one cycle, the snoop wins. The processor gets no completion and no bus request that cycle, and the request is then served against the updated state: a pending upgrade whose line was invalidated becomes operation 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present, held until done |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Processor address |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_op | output | 2 | Requested operation code |
| bus_req_addr | output | AW | Requested transaction address |
| bus_gnt | input | 1 | Arbiter grant for the current request |
| bus_shared_in | input | 1 | Another cache holds the line (read fill) |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snooped operation code |
| snp_addr | input | AW | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | Dirty line must be copied back for this snoop |

## Verification
A processor access and a snoop can land on the same line in the same cycle. The snoop must then win, and the processor access must be re-judged one cycle later against the changed state. The bench provokes this both by a directed invalidate that arrives while an upgrade waits for its grant, and by random snoops drawn from the same small address pool as the processor traffic. A lockstep state model in the bench predicts every output in every cycle, so a collision that leaks a completion or uses stale state shows up as a mismatch.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } mesi_e;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_RWITM = 2'd1,
      OP_INV   = 2'd2,
      OP_CPYBK = 2'd3
   } busop_e;
endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
   import mesi_pkg::*;
#(
   parameter int NLINES = 8,
   parameter int TAGW   = 13
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [$clog2(NLINES)-1:0]    rd_a_idx,
   output logic [TAGW-1:0]              rd_a_tag,
   output mesi_e                        rd_a_state,
   input  logic [$clog2(NLINES)-1:0]    rd_b_idx,
   output logic [TAGW-1:0]              rd_b_tag,
   output mesi_e                        rd_b_state,
   input  logic                         upd_a_en,
   input  logic [$clog2(NLINES)-1:0]    upd_a_idx,
   input  logic [TAGW-1:0]              upd_a_tag,
   input  mesi_e                        upd_a_state,
   input  logic                         upd_b_en,
   input  logic [$clog2(NLINES)-1:0]    upd_b_idx,
   input  mesi_e                        upd_b_state,
   output logic [NLINES-1:0][1:0]       state_vec
);
   localparam int IDXW = $clog2(NLINES);

   mesi_e           st_w  [NLINES];
   logic [TAGW-1:0] tag_w [NLINES];

   // Port b (snoop) has priority; the top never lets both touch one index.
   for (genvar i = 0; i < NLINES; i++) begin : g_line
      mesi_e           st_q;
      logic [TAGW-1:0] tag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= ST_I;
            tag_q <= '0;
         end else if (upd_b_en && upd_b_idx == IDXW'(i)) begin
            st_q <= upd_b_state;
         end else if (upd_a_en && upd_a_idx == IDXW'(i)) begin
            st_q  <= upd_a_state;
            tag_q <= upd_a_tag;
         end
      end
      assign st_w[i]      = st_q;
      assign tag_w[i]     = tag_q;
      assign state_vec[i] = st_q;
   end

   assign rd_a_tag   = tag_w[rd_a_idx];
   assign rd_a_state = st_w[rd_a_idx];
   assign rd_b_tag   = tag_w[rd_b_idx];
   assign rd_b_state = st_w[rd_b_idx];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
   import mesi_pkg::*;
#(
   parameter int TAGW = 13
) (
   input  logic            snp_valid,
   input  busop_e          snp_op,
   input  logic [TAGW-1:0] snp_tag,
   input  logic [TAGW-1:0] line_tag,
   input  mesi_e           line_state,
   output logic            snp_shared,
   output logic            snp_flush,
   output logic            upd_en,
   output mesi_e           upd_state
);
   logic hit;

   always_comb begin
      hit        = snp_valid && (line_state != ST_I) && (line_tag == snp_tag);
      snp_shared = hit && (snp_op == OP_READ);
      snp_flush  = hit && (line_state == ST_M) && (snp_op != OP_CPYBK);
      upd_en     = hit && (snp_op != OP_CPYBK);
      upd_state  = (snp_op == OP_READ) ? ST_S : ST_I;
   end
endmodule

// File: rtl/mesi_cpu_ctrl.sv
module mesi_cpu_ctrl
   import mesi_pkg::*;
#(
   parameter int TAGW = 13,
   parameter int IDXW = 3
) (
   input  logic                 cpu_valid,
   input  logic                 cpu_write,
   input  logic [TAGW-1:0]      cpu_tag,
   input  logic [IDXW-1:0]      cpu_idx,
   input  logic [TAGW-1:0]      line_tag,
   input  mesi_e                line_state,
   input  logic                 blocked,
   input  logic                 bus_gnt,
   input  logic                 bus_shared_in,
   output logic                 cpu_done,
   output logic                 bus_req_valid,
   output busop_e               bus_req_op,
   output logic [TAGW+IDXW-1:0] bus_req_addr,
   output logic                 upd_en,
   output logic [TAGW-1:0]      upd_tag,
   output mesi_e                upd_state
);
   logic hit, serve, victim_dirty, active, granted;

   always_comb begin
      hit          = (line_state != ST_I) && (line_tag == cpu_tag);
      serve        = hit && (!cpu_write || line_state != ST_S);
      victim_dirty = (line_state == ST_M) && (line_tag != cpu_tag);

      if (hit && cpu_write && line_state == ST_S) bus_req_op = OP_INV;
      else if (victim_dirty)                      bus_req_op = OP_CPYBK;
      else if (cpu_write)                         bus_req_op = OP_RWITM;
      else                                        bus_req_op = OP_READ;

      active        = cpu_valid && !blocked;
      bus_req_valid = active && !serve;
      granted       = bus_req_valid && bus_gnt;
      cpu_done      = (active && serve) || (granted && bus_req_op != OP_CPYBK);
      bus_req_addr  = (bus_req_op == OP_CPYBK) ? {line_tag, cpu_idx} : {cpu_tag, cpu_idx};

      upd_en    = (active && serve && cpu_write && line_state != ST_M) || granted;
      upd_tag   = cpu_tag;
      upd_state = ST_M;
      if (granted) begin
         unique case (bus_req_op)
            OP_CPYBK: begin
               upd_state = ST_I;
               upd_tag   = line_tag;
            end
            OP_READ:  upd_state = bus_shared_in ? ST_S : ST_E;
            default:  upd_state = ST_M;
         endcase
      end
   end
endmodule

// File: rtl/mesi_snoop_cache.sv
module mesi_snoop_cache
   import mesi_pkg::*;
#(
   parameter int AW     = 16,
   parameter int NLINES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_valid,
   input  logic          cpu_write,
   input  logic [AW-1:0] cpu_addr,
   output logic          cpu_done,
   output logic          bus_req_valid,
   output logic [1:0]    bus_req_op,
   output logic [AW-1:0] bus_req_addr,
   input  logic          bus_gnt,
   input  logic          bus_shared_in,
   input  logic          snp_valid,
   input  logic [1:0]    snp_op,
   input  logic [AW-1:0] snp_addr,
   output logic          snp_shared,
   output logic          snp_flush
);
   localparam int IDXW = $clog2(NLINES);
   localparam int TAGW = AW - IDXW;

   if (NLINES < 2 || (1 << IDXW) != NLINES) begin : g_bad_lines
      $error("NLINES must be a power of two of at least 2");
   end
   if (TAGW < 1) begin : g_bad_aw
      $error("AW must exceed the index width");
   end

   logic [IDXW-1:0]        cpu_idx, snp_idx;
   logic [TAGW-1:0]        cpu_tag, snp_tag;
   logic [TAGW-1:0]        cpu_line_tag, snp_line_tag;
   mesi_e                  cpu_line_state, snp_line_state;
   logic                   blocked;
   logic                   c_upd_en, s_upd_en;
   logic [TAGW-1:0]        c_upd_tag;
   mesi_e                  c_upd_state, s_upd_state;
   busop_e                 req_op;
   logic [NLINES-1:0][1:0] state_vec;

   assign cpu_idx = cpu_addr[IDXW-1:0];
   assign cpu_tag = cpu_addr[AW-1:IDXW];
   assign snp_idx = snp_addr[IDXW-1:0];
   assign snp_tag = snp_addr[AW-1:IDXW];
   assign blocked = snp_valid && (snp_idx == cpu_idx);

   mesi_line_array #(.NLINES(NLINES), .TAGW(TAGW)) lines_i (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(cpu_idx), .rd_a_tag(cpu_line_tag), .rd_a_state(cpu_line_state),
      .rd_b_idx(snp_idx), .rd_b_tag(snp_line_tag), .rd_b_state(snp_line_state),
      .upd_a_en(c_upd_en), .upd_a_idx(cpu_idx), .upd_a_tag(c_upd_tag), .upd_a_state(c_upd_state),
      .upd_b_en(s_upd_en), .upd_b_idx(snp_idx), .upd_b_state(s_upd_state),
      .state_vec(state_vec)
   );

   mesi_snoop_resp #(.TAGW(TAGW)) snoop_i (
      .snp_valid(snp_valid), .snp_op(busop_e'(snp_op)), .snp_tag(snp_tag),
      .line_tag(snp_line_tag), .line_state(snp_line_state),
      .snp_shared(snp_shared), .snp_flush(snp_flush),
      .upd_en(s_upd_en), .upd_state(s_upd_state)
   );

   mesi_cpu_ctrl #(.TAGW(TAGW), .IDXW(IDXW)) ctrl_i (
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_tag(cpu_tag), .cpu_idx(cpu_idx),
      .line_tag(cpu_line_tag), .line_state(cpu_line_state), .blocked(blocked),
      .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
      .cpu_done(cpu_done), .bus_req_valid(bus_req_valid), .bus_req_op(req_op),
      .bus_req_addr(bus_req_addr),
      .upd_en(c_upd_en), .upd_tag(c_upd_tag), .upd_state(c_upd_state)
   );

   assign bus_req_op = req_op;
endmodule

// File: rtl/mesi_snoop_cache_chk.sv
module mesi_snoop_cache_chk
   import mesi_pkg::*;
#(
   parameter int NLINES = 8,
   parameter int TAGW   = 13,
   parameter int IDXW   = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cpu_valid,
   input logic                   cpu_write,
   input logic [TAGW-1:0]        cpu_tag,
   input logic [IDXW-1:0]        cpu_idx,
   input logic [TAGW-1:0]        cpu_line_tag,
   input logic [1:0]             cpu_line_state,
   input logic                   cpu_done,
   input logic                   bus_req_valid,
   input logic [1:0]             bus_req_op,
   input logic                   snp_valid,
   input logic [1:0]             snp_op,
   input logic [TAGW-1:0]        snp_tag,
   input logic [IDXW-1:0]        snp_idx,
   input logic [TAGW-1:0]        snp_line_tag,
   input logic [1:0]             snp_line_state,
   input logic                   snp_flush,
   input logic [NLINES-1:0][1:0] state_vec
);
   logic cpu_hit, snp_hit;
   assign cpu_hit = (cpu_line_state != ST_I) && (cpu_line_tag == cpu_tag);
   assign snp_hit = snp_valid && (snp_line_state != ST_I) && (snp_line_tag == snp_tag);

   p_rdhit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !cpu_write && cpu_hit) |-> !bus_req_valid);

   p_write_lands_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && cpu_write) |=> (state_vec[$past(cpu_idx)] == ST_M));

   p_inv_from_shared_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_req_op == OP_INV) |-> (cpu_write && cpu_line_state == ST_S));

   p_cpybk_dirty_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_req_op == OP_CPYBK) |-> (cpu_line_state == ST_M && cpu_line_tag != cpu_tag));

   p_flush_needs_m_r8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> (snp_line_state == ST_M));

   p_snoop_read_shares_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_hit && snp_op == OP_READ) |=> (state_vec[$past(snp_idx)] == ST_S));

   p_snoop_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_hit && (snp_op == OP_RWITM || snp_op == OP_INV)) |=> (state_vec[$past(snp_idx)] == ST_I));

   p_snoop_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && snp_valid && snp_idx == cpu_idx) |-> (!cpu_done && !bus_req_valid));
endmodule

bind mesi_snoop_cache mesi_snoop_cache_chk #(.NLINES(NLINES), .TAGW(TAGW), .IDXW(IDXW)) chk_i (
   .clk(clk), .rst_n(rst_n),
   .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_tag(cpu_tag), .cpu_idx(cpu_idx),
   .cpu_line_tag(cpu_line_tag), .cpu_line_state(cpu_line_state),
   .cpu_done(cpu_done), .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op),
   .snp_valid(snp_valid), .snp_op(snp_op), .snp_tag(snp_tag), .snp_idx(snp_idx),
   .snp_line_tag(snp_line_tag), .snp_line_state(snp_line_state),
   .snp_flush(snp_flush), .state_vec(state_vec)
);

// File: tb/mesi_snoop_cache_tb_top.sv
module mesi_snoop_cache_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_valid = 1'b0, cpu_write = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_done, bus_req_valid;
   logic [1:0]  bus_req_op;
   logic [15:0] bus_req_addr;
   logic        bus_gnt = 1'b0, bus_shared_in = 1'b0;
   logic        snp_valid = 1'b0;
   logic [1:0]  snp_op = '0;
   logic [15:0] snp_addr = '0;
   logic        snp_shared, snp_flush;

   int total = 0, bad = 0;
   // bench model: 0 = I, 1 = S, 2 = E, 3 = M
   int mst [8];
   int mtag[8];

   always #4 clk = ~clk;   // 125 MHz

   mesi_snoop_cache dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_done(cpu_done),
      .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op), .bus_req_addr(bus_req_addr),
      .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
      .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
      .snp_shared(snp_shared), .snp_flush(snp_flush)
   );

   function automatic logic [15:0] pool_addr();
      return 16'((($urandom % 4) << 3) | ($urandom % 8));
   endfunction

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One clock cycle: drive, predict, compare, advance the model.
   task automatic cyc(input bit cv, input bit w, input logic [15:0] ca,
                      input bit sv, input logic [1:0] so, input logic [15:0] sa,
                      input bit g, input bit sh, output bit done_o);
      int ci, ct, si, st, eop;
      bit conflict, shit, chit, serv, ereq, edone, esh, efl;
      logic [15:0] eaddr;
      string creq, sreq;
      @(negedge clk);
      cpu_valid = cv; cpu_write = w; cpu_addr = ca;
      snp_valid = sv; snp_op = so; snp_addr = sa;
      bus_gnt = g; bus_shared_in = sh;
      #2;
      ci = int'(ca[2:0]); ct = int'(ca[15:3]);
      si = int'(sa[2:0]); st = int'(sa[15:3]);
      conflict = cv && sv && (si == ci);
      shit = sv && mst[si] != 0 && mtag[si] == st;
      esh  = shit && so == 2'd0;
      efl  = shit && mst[si] == 3 && so != 2'd3;
      chit = mst[ci] != 0 && mtag[ci] == ct;
      serv = chit && (!w || mst[ci] != 1);
      ereq = cv && !conflict && !serv;
      if (chit && w && mst[ci] == 1)                  eop = 2;
      else if (mst[ci] == 3 && mtag[ci] != ct)        eop = 3;
      else                                            eop = w ? 1 : 0;
      eaddr = (eop == 3) ? {mtag[ci][12:0], ca[2:0]} : ca;
      edone = cv && !conflict && (serv || (ereq && g && eop != 3));

      if (!cv)               creq = "R1";
      else if (conflict)     creq = "R11";
      else if (eop == 3)     creq = "R7";
      else if (serv && !w)   creq = "R2";
      else if (serv)         creq = "R3";
      else if (eop == 2)     creq = "R4";
      else if (w)            creq = "R6";
      else                   creq = "R5";
      if (!sv)               sreq = "R1";
      else if (!shit || so == 2'd3) sreq = "R10";
      else if (so == 2'd0)   sreq = "R8";
      else                   sreq = "R9";

      check(creq, {cpu_done, bus_req_valid, bus_req_valid ? bus_req_op : 2'd0,
                   bus_req_valid ? bus_req_addr : 16'd0, 16'd0},
                  {edone, ereq, ereq ? 2'(eop) : 2'd0, ereq ? eaddr : 16'd0, 16'd0});
      check(sreq, {34'd0, snp_shared, snp_flush}, {34'd0, esh, efl});

      @(posedge clk);
      if (shit && so == 2'd0) mst[si] = 1;
      else if (shit && so != 2'd3) mst[si] = 0;
      if (cv && !conflict) begin
         if (serv && w) mst[ci] = 3;
         else if (ereq && g) begin
            if (eop == 3) mst[ci] = 0;
            else begin
               mtag[ci] = ct;
               mst[ci]  = (eop == 0) ? (sh ? 1 : 2) : 3;
            end
         end
      end
      done_o = edone;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      bit d, pend, pw;
      logic [15:0] pa;
      void'($urandom(32'd4242));
      for (int i = 0; i < 8; i++) begin mst[i] = 0; mtag[i] = 0; end
      repeat (3) @(posedge clk);
      #1;
      // R1: quiet outputs under reset
      check("R1", {32'd0, cpu_done, bus_req_valid, snp_shared, snp_flush}, 36'd0);
      @(negedge clk); rst_n = 1'b1;

      // R5: read miss to 0x0011, alone on the bus -> Exclusive
      cyc(1, 0, 16'h0011, 0, 0, 0, 0, 0, d);
      cyc(1, 0, 16'h0011, 0, 0, 0, 1, 0, d);
      // R3: write hit on Exclusive, no bus
      cyc(1, 1, 16'h0011, 0, 0, 0, 0, 0, d);
      // R8: snooped read hits Modified -> flush + shared
      cyc(0, 0, 0, 1, 2'd0, 16'h0011, 0, 0, d);
      // R2: read hit on Shared
      cyc(1, 0, 16'h0011, 0, 0, 0, 1, 0, d);
      // R4: write hit on Shared -> invalidate, then grant
      cyc(1, 1, 16'h0011, 0, 0, 0, 0, 0, d);
      cyc(1, 1, 16'h0011, 0, 0, 0, 1, 0, d);
      // R7: read to other tag on dirty line -> copyback, then fill as Shared (R5)
      cyc(1, 0, 16'h0091, 0, 0, 0, 1, 0, d);
      cyc(1, 0, 16'h0091, 0, 0, 0, 1, 1, d);
      // R11: upgrade pending while a snooped invalidate hits the same line
      cyc(1, 1, 16'h0091, 1, 2'd2, 16'h0091, 1, 0, d);
      // R6: now a write miss -> RWITM
      cyc(1, 1, 16'h0091, 0, 0, 0, 1, 0, d);
      // R9: snooped RWITM on Modified -> flush, Invalid
      cyc(0, 0, 0, 1, 2'd1, 16'h0091, 0, 0, d);
      // R10: snoop to the now Invalid line and to an unrelated tag
      cyc(0, 0, 0, 1, 2'd0, 16'h0091, 0, 0, d);
      cyc(1, 0, 16'h0025, 0, 0, 0, 1, 0, d);
      cyc(0, 0, 0, 1, 2'd1, 16'h00A5, 0, 0, d);
      // R7: Exclusive victim dropped without copyback
      cyc(1, 0, 16'h00A5, 0, 0, 0, 1, 0, d);

      // constrained random traffic on a small address pool
      pend = 0; pw = 0; pa = '0;
      for (int n = 0; n < 4000; n++) begin
         bit sv, g, sh;
         logic [1:0] so;
         logic [15:0] sa;
         if (!pend && ($urandom % 3) != 0) begin
            pend = 1; pw = 1'($urandom % 2); pa = pool_addr();
         end
         sv = ($urandom % 10) < 3;
         so = 2'($urandom % 4);
         sa = pool_addr();
         g  = 1'($urandom % 2);
         sh = 1'($urandom % 2);
         cyc(pend, pw, pa, sv, so, sa, g, sh, d);
         if (d) pend = 0;
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule